// File: doc/BRIEF.md
# Receive Frame Admission and Status

This block sits on the receive path between the MAC byte stream and the receive data and status FIFOs. Each input beat carries one byte, with flags that mark the first byte, the last byte and a byte-level error. The block decides for every frame whether it is admitted. For an admitted frame it forwards the bytes to the data FIFO and strips padding and CRC from minimum-size frames when asked to. It marks oversize frames. At the end of each admitted frame it pulses a done signal, with a discard flag that tells the data FIFO to roll back the frame it has just written.

A small control register holds the receive policy: receive enable, receive halt, drop-on-error, keep-dropped-status, jumbo acceptance, pad stripping and a sticky soft reset. A frame that is not dropped, or any admitted frame when keep-dropped-status is set, produces one status word. The status word holds the forwarded byte count and the error, oversize and dropped flags. The FIFO storage, the CRC computation and the PHY side are outside the block.

Top module: `rx_frame_admit`

## Requirements
- R1: `cfg_we_i` loads every control field from its `cfg_*_i` pin at the clock edge. All fields reset to 0. A write with `cfg_soft_rst_i`=1 instead makes `rx_en_o`=0 and `rx_halt_o`=1, whatever those pins carry. `soft_rst_o` then stays 1 until a write with `cfg_soft_rst_i`=0.
- R2: A frame whose first byte arrives while `rx_en_o`=0 or `rx_halt_o`=1 is ignored completely. It produces no output byte, no done pulse and no status word.
- R3: When receive enable is found clear while a frame is in progress, the frame is aborted. One cycle later `fr_done_o`=1 and `fr_discard_o`=1, with no status word. The remaining bytes of that frame are ignored.
- R4: Setting halt during a frame lets that frame complete normally. Later frames are ignored while halt stays set.
- R5: Each byte of an admitted frame that is not stripped appears on `out_data_o` with `out_valid_o`=1 exactly one cycle after its input beat, in order.
- R6: For an admitted frame, `fr_done_o` pulses for one cycle in the cycle after the last-byte beat. For a frame that is not dropped, `stat_valid_o` pulses in the same cycle. `stat_len_o` then equals the number of forwarded bytes, and `fr_discard_o`=0.
- R7: With drop-on-error set, an error flag on a byte whose index within the frame is 0 to 255 drops the frame. The done pulse then carries `fr_discard_o`=1, and no status word is written while keep-dropped-status is clear.
- R8: With keep-dropped-status set, a dropped frame still produces a status word. That word has `stat_len_o`=0, `stat_drop_o`=1 and `stat_err_o`=1.
- R9: An error on a byte at index 256 or later, or any error while drop-on-error is clear, does not drop the frame. The frame is forwarded in full and its status carries `stat_err_o`=1 and `stat_drop_o`=0.
- R10: A frame longer than 1518 bytes sets `stat_oversize_o` while jumbo acceptance is clear. With jumbo acceptance set, the flag is 0. A frame of exactly 1518 bytes never sets it.
- R11: With pad stripping set, the length/type field is read from byte 12 (high) and byte 13 (low). When that field value L is 46 or less, bytes at index 14+L and above are not forwarded, and `stat_len_o` is 14+L. If such a frame is not exactly 64 bytes long, `stat_err_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_rx_en_i | input | 1 | Receive enable value to write |
| cfg_rx_halt_i | input | 1 | Receive halt value to write |
| cfg_drop_err_i | input | 1 | Drop-on-early-error value to write |
| cfg_keep_drop_i | input | 1 | Keep-dropped-status value to write |
| cfg_jumbo_i | input | 1 | Jumbo acceptance value to write |
| cfg_strip_pad_i | input | 1 | Pad/CRC stripping value to write |
| cfg_soft_rst_i | input | 1 | Soft reset value to write |
| rx_en_o | output | 1 | Current receive enable |
| rx_halt_o | output | 1 | Current receive halt |
| soft_rst_o | output | 1 | Current soft reset bit |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_sof_i | input | 1 | Byte is the first of a frame |
| in_eof_i | input | 1 | Byte is the last of a frame |
| in_err_i | input | 1 | Error seen on this byte |
| out_valid_o | output | 1 | Forwarded byte valid |
| out_data_o | output | 8 | Forwarded byte |
| fr_done_o | output | 1 | Frame finished or aborted |
| fr_discard_o | output | 1 | With done: roll back the frame |
| stat_valid_o | output | 1 | Status word write strobe |
| stat_len_o | output | CNT_W | Forwarded byte count (0 when dropped) |
| stat_err_o | output | 1 | Frame had an error |
| stat_oversize_o | output | 1 | Frame over the standard maximum |
| stat_drop_o | output | 1 | Frame was dropped |

## Verification
The assertions assume well-formed framing on the input. Every first-byte flag is followed by exactly one last-byte flag before the next frame starts, and no first-byte flag appears inside a frame. If a first byte appeared mid-frame, the admission state and the counters would merge two frames. The bench builds every frame with a single start and a single end. It writes the control register only in idle cycles, including the enable and halt changes it makes mid-frame, which it places in gaps between beats. As a result, the abort and halt cases are reached through the intended path and never through a collision with a data beat.

// File: rtl/rx_frame_admit_pkg.sv
`timescale 1ns/1ps
package rx_frame_admit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_SKIP = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic soft_rst;
    logic strip_pad;
    logic jumbo;
    logic keep_drop;
    logic drop_err;
    logic rx_halt;
    logic rx_en;
  } rx_cfg_t;

  localparam int unsigned LEN_FIELD_W = 16;

endpackage

// File: rtl/rx_frame_admit_cfg.sv
`timescale 1ns/1ps
module rx_frame_admit_cfg
  import rx_frame_admit_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    we_i,
  input  rx_cfg_t wdata_i,
  output rx_cfg_t cfg_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (we_i) begin
      cfg_o <= wdata_i;
      // soft reset overrides enable/halt for as long as it is written set
      if (wdata_i.soft_rst) begin
        cfg_o.rx_en   <= 1'b0;
        cfg_o.rx_halt <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_frame_admit_fsm.sv
`timescale 1ns/1ps
module rx_frame_admit_fsm
  import rx_frame_admit_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sof_i,
  input  logic eof_i,
  input  logic en_i,
  input  logic halt_i,
  output logic take_o,
  output logic end_o,
  output logic abort_o
);

  rx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    take_o  = 1'b0;
    abort_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (valid_i && sof_i) begin
          if (en_i && !halt_i) begin
            take_o = 1'b1;
            if (!eof_i) state_d = ST_RECV;
          end else if (!eof_i) begin
            state_d = ST_SKIP;
          end
        end
      end
      ST_RECV: begin
        if (!en_i) begin
          abort_o = 1'b1;
          state_d = (valid_i && eof_i) ? ST_IDLE : ST_SKIP;
        end else if (valid_i) begin
          take_o = 1'b1;
          if (eof_i) state_d = ST_IDLE;
        end
      end
      ST_SKIP: begin
        if (valid_i && eof_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign end_o = take_o & eof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/rx_frame_admit_track.sv
`timescale 1ns/1ps
module rx_frame_admit_track
  import rx_frame_admit_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned MAX_LEN  = 1518,
  parameter int unsigned DROP_WIN = 256,
  parameter int unsigned MIN_LEN  = 64,
  parameter int unsigned HDR_LEN  = 14,
  parameter int unsigned PAD_MAX  = 46
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             sof_i,
  input  logic [7:0]       data_i,
  input  logic             err_i,
  input  logic             strip_i,
  input  logic             drop_err_i,
  input  logic             jumbo_i,
  output logic             fwd_o,
  output logic [CNT_W-1:0] fwd_len_o,
  output logic             err_o,
  output logic             oversize_o,
  output logic             drop_o
);

  localparam logic [CNT_W-1:0]       ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0]       L_MAX  = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0]       L_WIN  = CNT_W'(DROP_WIN);
  localparam logic [CNT_W-1:0]       L_MIN  = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0]       L_HDR  = CNT_W'(HDR_LEN);
  localparam logic [CNT_W-1:0]       L_TYLO = CNT_W'(HDR_LEN - 1);
  localparam logic [CNT_W-1:0]       L_TYHI = CNT_W'(HDR_LEN - 2);
  localparam logic [LEN_FIELD_W-1:0] L_PAD  = LEN_FIELD_W'(PAD_MAX);

  logic [CNT_W-1:0]       cnt_q, fwd_q;
  logic                   err_q, early_q;
  logic [7:0]             len_hi_q;
  logic [LEN_FIELD_W-1:0] len_q;

  logic [CNT_W-1:0]       idx, tot, fwd_acc;
  logic [LEN_FIELD_W-1:0] len_cur;
  logic                   strip_beat, pad_frame, pad_err, err_acc, early_acc;

  assign idx = sof_i ? '0 : cnt_q;
  assign tot = (idx == '1) ? idx : idx + ONE;

  assign len_cur = (idx == L_TYLO) ? {len_hi_q, data_i} : len_q;

  // bytes past header + declared payload are padding or CRC
  assign strip_beat = strip_i && (idx >= L_HDR) && (len_q <= L_PAD) &&
                      ((idx - L_HDR) >= CNT_W'(len_q));

  assign fwd_o     = take_i && !strip_beat;
  assign fwd_acc   = (sof_i ? '0 : fwd_q) + (fwd_o ? ONE : '0);
  assign pad_frame = strip_i && (idx >= L_TYLO) && (len_cur <= L_PAD);
  assign pad_err   = pad_frame && (tot != L_MIN);
  assign err_acc   = (sof_i ? 1'b0 : err_q) | err_i;
  assign early_acc = (sof_i ? 1'b0 : early_q) | (err_i && (idx < L_WIN));

  assign fwd_len_o  = fwd_acc;
  assign err_o      = err_acc | pad_err;
  assign oversize_o = (tot > L_MAX) && !jumbo_i;
  assign drop_o     = drop_err_i && early_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      fwd_q    <= '0;
      err_q    <= 1'b0;
      early_q  <= 1'b0;
      len_hi_q <= '0;
      len_q    <= '0;
    end else if (take_i) begin
      cnt_q   <= tot;
      fwd_q   <= fwd_acc;
      err_q   <= err_acc;
      early_q <= early_acc;
      if (idx == L_TYHI) len_hi_q <= data_i;
      if (idx == L_TYLO) len_q    <= {len_hi_q, data_i};
    end
  end

endmodule

// File: rtl/rx_frame_admit_stat.sv
`timescale 1ns/1ps
module rx_frame_admit_stat #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fwd_i,
  input  logic [7:0]       data_i,
  input  logic             end_i,
  input  logic             abort_i,
  input  logic             drop_i,
  input  logic             keep_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             err_i,
  input  logic             oversize_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             done_o,
  output logic             discard_o,
  output logic             stat_valid_o,
  output logic [CNT_W-1:0] stat_len_o,
  output logic             stat_err_o,
  output logic             stat_oversize_o,
  output logic             stat_drop_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o     <= 1'b0;
      out_data_o      <= '0;
      done_o          <= 1'b0;
      discard_o       <= 1'b0;
      stat_valid_o    <= 1'b0;
      stat_len_o      <= '0;
      stat_err_o      <= 1'b0;
      stat_oversize_o <= 1'b0;
      stat_drop_o     <= 1'b0;
    end else begin
      out_valid_o  <= fwd_i;
      if (fwd_i) out_data_o <= data_i;
      done_o       <= end_i | abort_i;
      discard_o    <= abort_i | (end_i & drop_i);
      stat_valid_o <= end_i & (!drop_i | keep_i);
      if (end_i) begin
        stat_len_o      <= drop_i ? '0 : len_i;
        stat_err_o      <= err_i;
        stat_oversize_o <= oversize_i;
        stat_drop_o     <= drop_i;
      end
    end
  end

endmodule

// File: rtl/rx_frame_admit.sv
`timescale 1ns/1ps
module rx_frame_admit
  import rx_frame_admit_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned MAX_LEN  = 1518,
  parameter int unsigned DROP_WIN = 256,
  parameter int unsigned MIN_LEN  = 64,
  parameter int unsigned HDR_LEN  = 14,
  parameter int unsigned PAD_MAX  = 46
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_rx_en_i,
  input  logic             cfg_rx_halt_i,
  input  logic             cfg_drop_err_i,
  input  logic             cfg_keep_drop_i,
  input  logic             cfg_jumbo_i,
  input  logic             cfg_strip_pad_i,
  input  logic             cfg_soft_rst_i,
  output logic             rx_en_o,
  output logic             rx_halt_o,
  output logic             soft_rst_o,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_sof_i,
  input  logic             in_eof_i,
  input  logic             in_err_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             fr_done_o,
  output logic             fr_discard_o,
  output logic             stat_valid_o,
  output logic [CNT_W-1:0] stat_len_o,
  output logic             stat_err_o,
  output logic             stat_oversize_o,
  output logic             stat_drop_o
);

  rx_cfg_t          cfg_wdata, cfg_q;
  logic             take, fr_end, abort;
  logic             fwd, err_any, oversize, drop;
  logic [CNT_W-1:0] fwd_len;

  assign cfg_wdata = '{soft_rst:  cfg_soft_rst_i,
                       strip_pad: cfg_strip_pad_i,
                       jumbo:     cfg_jumbo_i,
                       keep_drop: cfg_keep_drop_i,
                       drop_err:  cfg_drop_err_i,
                       rx_halt:   cfg_rx_halt_i,
                       rx_en:     cfg_rx_en_i};

  rx_frame_admit_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata),
    .cfg_o   (cfg_q)
  );

  assign rx_en_o    = cfg_q.rx_en;
  assign rx_halt_o  = cfg_q.rx_halt;
  assign soft_rst_o = cfg_q.soft_rst;

  rx_frame_admit_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .sof_i   (in_sof_i),
    .eof_i   (in_eof_i),
    .en_i    (cfg_q.rx_en),
    .halt_i  (cfg_q.rx_halt),
    .take_o  (take),
    .end_o   (fr_end),
    .abort_o (abort)
  );

  rx_frame_admit_track #(
    .CNT_W    (CNT_W),
    .MAX_LEN  (MAX_LEN),
    .DROP_WIN (DROP_WIN),
    .MIN_LEN  (MIN_LEN),
    .HDR_LEN  (HDR_LEN),
    .PAD_MAX  (PAD_MAX)
  ) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .sof_i      (in_sof_i),
    .data_i     (in_data_i),
    .err_i      (in_err_i),
    .strip_i    (cfg_q.strip_pad),
    .drop_err_i (cfg_q.drop_err),
    .jumbo_i    (cfg_q.jumbo),
    .fwd_o      (fwd),
    .fwd_len_o  (fwd_len),
    .err_o      (err_any),
    .oversize_o (oversize),
    .drop_o     (drop)
  );

  rx_frame_admit_stat #(.CNT_W(CNT_W)) u_stat (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .fwd_i           (fwd),
    .data_i          (in_data_i),
    .end_i           (fr_end),
    .abort_i         (abort),
    .drop_i          (drop),
    .keep_i          (cfg_q.keep_drop),
    .len_i           (fwd_len),
    .err_i           (err_any),
    .oversize_i      (oversize),
    .out_valid_o     (out_valid_o),
    .out_data_o      (out_data_o),
    .done_o          (fr_done_o),
    .discard_o       (fr_discard_o),
    .stat_valid_o    (stat_valid_o),
    .stat_len_o      (stat_len_o),
    .stat_err_o      (stat_err_o),
    .stat_oversize_o (stat_oversize_o),
    .stat_drop_o     (stat_drop_o)
  );

endmodule

// File: rtl/rx_frame_admit_chk.sv
`timescale 1ns/1ps
module rx_frame_admit_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             rx_en_o,
  input logic             rx_halt_o,
  input logic             soft_rst_o,
  input logic             out_valid_o,
  input logic             fr_done_o,
  input logic             fr_discard_o,
  input logic             stat_valid_o,
  input logic [CNT_W-1:0] stat_len_o,
  input logic             stat_err_o,
  input logic             stat_drop_o
);

  p_soft_forces_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (!rx_en_o && rx_halt_o));

  p_soft_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(soft_rst_o) && !$past(cfg_we_i)) |-> soft_rst_o);

  p_no_fwd_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rx_en_o) |-> !out_valid_o);

  p_discard_in_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_discard_o |-> fr_done_o);

  p_stat_with_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> fr_done_o);

  p_kept_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && !stat_drop_o) |-> !fr_discard_o);

  p_drop_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_drop_o) |-> (stat_len_o == '0 && stat_err_o && fr_discard_o));

endmodule

bind rx_frame_admit rx_frame_admit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .rx_en_o      (rx_en_o),
  .rx_halt_o    (rx_halt_o),
  .soft_rst_o   (soft_rst_o),
  .out_valid_o  (out_valid_o),
  .fr_done_o    (fr_done_o),
  .fr_discard_o (fr_discard_o),
  .stat_valid_o (stat_valid_o),
  .stat_len_o   (stat_len_o),
  .stat_err_o   (stat_err_o),
  .stat_drop_o  (stat_drop_o)
);

// File: tb/rx_frame_admit_test.sv
`timescale 1ns/1ps
module rx_frame_admit_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_rx_en_i = 1'b0, cfg_rx_halt_i = 1'b0, cfg_drop_err_i = 1'b0;
  logic        cfg_keep_drop_i = 1'b0, cfg_jumbo_i = 1'b0, cfg_strip_pad_i = 1'b0;
  logic        cfg_soft_rst_i = 1'b0;
  logic        rx_en_o, rx_halt_o, soft_rst_o;
  logic        in_valid_i = 1'b0, in_sof_i = 1'b0, in_eof_i = 1'b0, in_err_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        out_valid_o, fr_done_o, fr_discard_o;
  logic [7:0]  out_data_o;
  logic        stat_valid_o, stat_err_o, stat_oversize_o, stat_drop_o;
  logic [15:0] stat_len_o;

  always #2.5 clk_i = ~clk_i;

  rx_frame_admit uut (.*);

  int n_chk = 0;
  int n_fail = 0;

  bit b_en, b_halt, b_drop, b_keep, b_jumbo, b_strip, b_soft;

  logic [7:0]  q_byte[$];
  string       q_byte_t[$];
  logic        q_done[$];
  string       q_done_t[$];
  logic [18:0] q_stat[$];
  string       q_stat_t[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor, samples 1 ns after each rising edge
  always begin
    @(posedge clk_i);
    #1;
    if (rst_ni) begin
      if (out_valid_o) begin
        if (q_byte.size() == 0) chk("R2 unexpected output byte", {24'h0, out_data_o}, 32'hffff_ffff);
        else chk(q_byte_t.pop_front(), {24'h0, out_data_o}, {24'h0, q_byte.pop_front()});
      end
      if (fr_done_o) begin
        if (q_done.size() == 0) chk("R2 unexpected done pulse", 32'(fr_discard_o), 32'hffff_ffff);
        else chk(q_done_t.pop_front(), 32'(fr_discard_o), 32'(q_done.pop_front()));
      end else if (fr_discard_o) begin
        chk("R3 discard without done", 32'd1, 32'd0);
      end
      if (stat_valid_o) begin
        if (q_stat.size() == 0)
          chk("R2 unexpected status", {13'h0, stat_len_o, stat_err_o, stat_oversize_o, stat_drop_o}, 32'hffff_ffff);
        else
          chk(q_stat_t.pop_front(), {13'h0, stat_len_o, stat_err_o, stat_oversize_o, stat_drop_o},
              {13'h0, q_stat.pop_front()});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic logic [7:0] byte_at(input int i, input int lf);
    if (i == 12) return lf[15:8];
    if (i == 13) return lf[7:0];
    return 8'(i * 7 + 3);
  endfunction

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk_i);
      in_valid_i = 1'b0; in_sof_i = 1'b0; in_eof_i = 1'b0; in_err_i = 1'b0;
      cfg_we_i = 1'b0;
    end
  endtask

  task automatic wr_cfg();
    @(negedge clk_i);
    in_valid_i = 1'b0; in_sof_i = 1'b0; in_eof_i = 1'b0; in_err_i = 1'b0;
    cfg_rx_en_i = b_en; cfg_rx_halt_i = b_halt; cfg_drop_err_i = b_drop;
    cfg_keep_drop_i = b_keep; cfg_jumbo_i = b_jumbo; cfg_strip_pad_i = b_strip;
    cfg_soft_rst_i = b_soft;
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (b_soft) begin
      b_en = 1'b0;
      b_halt = 1'b1;
    end
  endtask

  task automatic beat(input logic [7:0] d, input logic s, input logic e, input logic r);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = d; in_sof_i = s; in_eof_i = e; in_err_i = r;
  endtask

  // driver: predicts bytes, done and status from the requirements, then drives
  task automatic send_frame(input string tag, input int n, input int lf,
                            input int errpos, input int halt_at);
    bit acc = b_en && !b_halt;
    int fwd = 0;
    bit drop, pad_err, err, ovs;
    for (int i = 0; i < n; i++) begin
      bit strip = b_strip && i >= 14 && lf <= 46 && i >= 14 + lf;
      if (acc && !strip) begin
        q_byte.push_back(byte_at(i, lf));
        q_byte_t.push_back({tag, " R5 byte"});
        fwd++;
      end
    end
    drop    = b_drop && errpos >= 0 && errpos < 256;
    pad_err = b_strip && n >= 14 && lf <= 46 && n != 64;
    err     = (errpos >= 0) || pad_err;
    ovs     = (n > 1518) && !b_jumbo;
    if (acc) begin
      q_done.push_back(drop);
      q_done_t.push_back({tag, " R6 done"});
      if (!drop || b_keep) begin
        q_stat.push_back({drop ? 16'h0 : 16'(fwd), err, ovs, drop});
        q_stat_t.push_back({tag, " R6 status"});
      end
    end
    for (int i = 0; i < n; i++) begin
      if (i == halt_at) begin
        b_halt = 1'b1;
        wr_cfg();
      end
      beat(byte_at(i, lf), i == 0, i == n - 1, i == errpos);
    end
    idle(1);
  endtask

  task automatic send_abort(input string tag, input int n, input int k);
    for (int i = 0; i < k; i++) begin
      q_byte.push_back(byte_at(i, 16'h0800));
      q_byte_t.push_back({tag, " R5 byte"});
    end
    q_done.push_back(1'b1);
    q_done_t.push_back({tag, " R3 abort discard"});
    for (int i = 0; i < k; i++) beat(byte_at(i, 16'h0800), i == 0, 1'b0, 1'b0);
    b_en = 1'b0;
    wr_cfg();
    idle(2);
    for (int i = k; i < n; i++) beat(byte_at(i, 16'h0800), 1'b0, i == n - 1, 1'b0);
    idle(1);
    b_en = 1'b1;
    wr_cfg();
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    chk("R1 reset enable", 32'(rx_en_o), 32'd0);
    chk("R1 reset halt", 32'(rx_halt_o), 32'd0);
    chk("R1 reset soft", 32'(soft_rst_o), 32'd0);
    chk("R6 reset stat_valid", 32'(stat_valid_o), 32'd0);
    chk("R5 reset out_valid", 32'(out_valid_o), 32'd0);

    send_frame("R2 disabled", 40, 16'h0800, -1, -1);
    idle(3);

    b_en = 1'b1;
    wr_cfg();
    chk("R1 enable written", 32'(rx_en_o), 32'd1);
    send_frame("R5 plain", 80, 16'h0800, -1, -1);
    send_frame("R6 min", 64, 16'h0806, -1, -1);

    b_drop = 1'b1;
    wr_cfg();
    send_frame("R7 early err", 80, 16'h0800, 10, -1);
    send_frame("R7 err idx255", 300, 16'h0800, 255, -1);
    send_frame("R9 err idx256", 300, 16'h0800, 256, -1);
    b_keep = 1'b1;
    wr_cfg();
    send_frame("R8 keep dropped", 80, 16'h0800, 3, -1);
    b_keep = 1'b0;
    b_drop = 1'b0;
    wr_cfg();
    send_frame("R9 no drop", 60, 16'h0800, 5, -1);

    send_frame("R10 max len", 1518, 16'h0800, -1, -1);
    send_frame("R10 oversize", 1519, 16'h0800, -1, -1);
    b_jumbo = 1'b1;
    wr_cfg();
    send_frame("R10 jumbo", 1600, 16'h0800, -1, -1);
    b_jumbo = 1'b0;

    b_strip = 1'b1;
    wr_cfg();
    send_frame("R11 pad L20", 64, 20, -1, -1);
    send_frame("R11 pad L46", 64, 46, -1, -1);
    send_frame("R11 type field", 64, 16'h0800, -1, -1);
    send_frame("R11 mismatch", 70, 10, -1, -1);
    b_strip = 1'b0;
    wr_cfg();
    send_frame("R11 strip off", 64, 20, -1, -1);

    send_abort("R3 abort", 100, 30);
    send_frame("R3 recover", 50, 16'h0800, -1, -1);

    send_frame("R4 halt mid", 80, 16'h0800, -1, 40);
    send_frame("R4 halted next", 40, 16'h0800, -1, -1);
    b_halt = 1'b0;
    wr_cfg();
    send_frame("R4 resumed", 30, 16'h0800, -1, -1);

    b_soft = 1'b1;
    wr_cfg();
    chk("R1 soft enable", 32'(rx_en_o), 32'd0);
    chk("R1 soft halt", 32'(rx_halt_o), 32'd1);
    chk("R1 soft bit", 32'(soft_rst_o), 32'd1);
    send_frame("R1 soft ignored", 30, 16'h0800, -1, -1);
    b_en = 1'b1;
    b_halt = 1'b0;
    wr_cfg();
    chk("R1 soft still forces", 32'(rx_en_o), 32'd0);
    b_soft = 1'b0;
    b_en = 1'b1;
    b_halt = 1'b0;
    wr_cfg();
    chk("R1 soft cleared", 32'(soft_rst_o), 32'd0);
    chk("R1 enable after clear", 32'(rx_en_o), 32'd1);
    send_frame("R1 after clear", 50, 16'h0800, -1, -1);

    idle(10);
    chk("R5 bytes outstanding", 32'(q_byte.size()), 32'd0);
    chk("R6 done outstanding", 32'(q_done.size()), 32'd0);
    chk("R6 status outstanding", 32'(q_stat.size()), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule